// File: doc/BRIEF.md
# SPI Event Collector and Interrupt Combiner

This block gathers single-cycle status pulses from an SPI controller's FIFOs and shift engine into nine sticky event flags. Software reads the flags through a small register port and clears them by writing ones. A mask register decides which flags may raise the interrupt. The block drives one interrupt line and a pending indication. A separate error summary output tells software that a fault-type event is present, whatever the mask says.

The register port has one write strobe and one read selector. `wr_sel_i`/`rd_sel_i` = 0 addresses the event flags and 1 addresses the mask. Reads are combinational from the current register contents. Writes take effect at the rising clock edge.

Event bit positions, shared by the event register, the mask register and `evt_pulse_i`:

| Bit | Event |
|-----|-------|
| 0 | master transfer done |
| 1 | slave transfer done |
| 2 | transmit FIFO request |
| 3 | transmit FIFO overflow |
| 4 | transmit FIFO underflow |
| 5 | receive FIFO request |
| 6 | receive FIFO overflow |
| 7 | receive FIFO underflow |
| 8 | mode mismatch |

Top module: `spi_evt_unit`

## Requirements
- R1: After reset the event register reads 0x000, the mask register reads 0x1FF, and `pend_o`, `irq_o` and `err_o` are 0.
- R2: A 1 on bit n of `evt_pulse_i` at a clock edge sets event bit n. The bit can be read from the next cycle on. It stays set after the pulse ends, and pulses on several bits accumulate by OR.
- R3: A write to the event register (`wr_sel_i`=0) clears each event bit whose data bit is 1. Bits whose data bit is 0 are left unchanged.
- R4: When a pulse and a write-one clear hit the same event bit at the same edge, the bit is set afterwards.
- R5: A write to the mask register (`wr_sel_i`=1) replaces its whole contents, and the new value reads back from the next cycle. A mask bit of 1 suppresses that event.
- R6: `pend_o` is 1 exactly when some event bit is set while its mask bit is 0, in the same cycle as the register contents.
- R7: `irq_o` equals the value `pend_o` had one cycle earlier.
- R8: `err_o` is 1 when any of event bits 1, 3, 4, 6, 7 or 8 is set, regardless of the mask. Bits 0, 2 and 5 never raise it.
- R9: A mask write leaves the event bits unchanged, and an event write leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse_i | input | 9 | One-cycle event pulses, one bit per event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 event, 1 mask |
| wr_data_i | input | 9 | Write data |
| rd_sel_i | input | 1 | Read source: 0 event, 1 mask |
| rd_data_o | output | 9 | Read data |
| pend_o | output | 1 | Some unmasked event is set |
| irq_o | output | 1 | Registered interrupt request |
| err_o | output | 1 | Some error-class event is set |

## Verification
The hardest case to reach is the collision of a new pulse with a write-one clear of the same bit in one cycle. The bench drives `evt_pulse_i` and the write strobe together in one cycle of a directed task, and then reads the flag back. The one-cycle lag between `pend_o` and `irq_o` is also checked. The bench samples both outputs on the cycle right after the unmasking write and on the cycle after that.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
    localparam int EVT_N = 9;

    localparam int EV_MDONE = 0;
    localparam int EV_SDONE = 1;
    localparam int EV_TXREQ = 2;
    localparam int EV_TXOVF = 3;
    localparam int EV_TXUNF = 4;
    localparam int EV_RXREQ = 5;
    localparam int EV_RXOVF = 6;
    localparam int EV_RXUNF = 7;
    localparam int EV_MMIS  = 8;

    localparam logic [EVT_N-1:0] ERR_CLASS =
        EVT_N'((1 << EV_SDONE) | (1 << EV_TXOVF) | (1 << EV_TXUNF) |
               (1 << EV_RXOVF) | (1 << EV_RXUNF) | (1 << EV_MMIS));

    typedef enum logic {
        SEL_EVT  = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/spi_evt_bank.sv
module spi_evt_bank #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] evt_o
);
    logic [W-1:0] evt_q;

    for (genvar i = 0; i < W; i++) begin : g_flag
        always_ff @(posedge clk_i) begin
            if (!rst_n)
                evt_q[i] <= 1'b0;
            else if (pulse_i[i])
                evt_q[i] <= 1'b1;
            else if (clr_i[i])
                evt_q[i] <= 1'b0;
        end
    end

    assign evt_o = evt_q;

    assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
        ((evt_q & ~clr_i) != '0) |=>
        ((evt_q & $past(evt_q & ~clr_i)) == $past(evt_q & ~clr_i)));

    assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
        ((clr_i & ~pulse_i) != '0) |=>
        ((evt_q & $past(clr_i & ~pulse_i)) == '0));

    assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
        (pulse_i != '0) |=> ((evt_q & $past(pulse_i)) == $past(pulse_i)));
endmodule

// File: rtl/spi_evt_mask.sv
module spi_evt_mask #(
    parameter int W = 9
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n)
            mask_q <= '1;
        else if (we_i)
            mask_q <= data_i;
    end

    assign mask_o = mask_q;

    assert_mask_load_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
        we_i |=> (mask_q == $past(data_i)));

    assert_mask_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
        !we_i |=> $stable(mask_q));
endmodule

// File: rtl/spi_evt_irq.sv
module spi_evt_irq #(
    parameter int W = 9,
    parameter logic [W-1:0] ERR_SET = '0
) (
    input  logic         clk_i,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] mask_i,
    output logic         pend_o,
    output logic         err_o,
    output logic         irq_o
);
    logic pend;
    logic irq_q;

    always_comb begin
        pend  = |(evt_i & ~mask_i);
        err_o = |(evt_i & ERR_SET);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= pend;
    end

    assign pend_o = pend;
    assign irq_o  = irq_q;

    assert_irq_lag_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        pend |=> irq_q);

    assert_irq_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        !pend |=> !irq_q);

    assert_all_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mask_i == '1) |-> !pend);
endmodule

// File: rtl/spi_evt_unit.sv
module spi_evt_unit
    import spi_evt_pkg::*;
#(
    parameter int EVT_W = EVT_N
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_pulse_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [EVT_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [EVT_W-1:0] rd_data_o,
    output logic             pend_o,
    output logic             irq_o,
    output logic             err_o
);
    localparam logic [EVT_W-1:0] ERR_SET = EVT_W'(ERR_CLASS);

    logic [EVT_W-1:0] evt;
    logic [EVT_W-1:0] mask;
    logic [EVT_W-1:0] clr;
    logic             mask_we;

    always_comb begin
        clr     = (wr_en_i && reg_sel_e'(wr_sel_i) == SEL_EVT) ? wr_data_i : '0;
        mask_we = wr_en_i && reg_sel_e'(wr_sel_i) == SEL_MASK;
    end

    spi_evt_bank #(.W(EVT_W)) u_bank (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .pulse_i (evt_pulse_i),
        .clr_i   (clr),
        .evt_o   (evt)
    );

    spi_evt_mask #(.W(EVT_W)) u_mask (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .we_i   (mask_we),
        .data_i (wr_data_i),
        .mask_o (mask)
    );

    spi_evt_irq #(.W(EVT_W), .ERR_SET(ERR_SET)) u_irq (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .mask_i (mask),
        .pend_o (pend_o),
        .err_o  (err_o),
        .irq_o  (irq_o)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel_i))
            SEL_EVT:  rd_data_o = evt;
            SEL_MASK: rd_data_o = mask;
        endcase
    end

    assert_evt_hold_on_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
        (mask_we && evt_pulse_i == '0) |=> $stable(evt));
endmodule

// File: tb/spi_evt_unit_test.sv
module spi_evt_unit_test;
    logic       clk_i = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] evt_pulse_i = '0;
    logic       wr_en_i = 1'b0;
    logic       wr_sel_i = 1'b0;
    logic [8:0] wr_data_i = '0;
    logic       rd_sel_i = 1'b0;
    logic [8:0] rd_data_o;
    logic       pend_o, irq_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk_i = ~clk_i;

    spi_evt_unit uut (
        .clk_i(clk_i), .rst_n(rst_n), .evt_pulse_i(evt_pulse_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .pend_o(pend_o),
        .irq_o(irq_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic rd_evt(output logic [8:0] v);
        rd_sel_i = 1'b0; #1; v = rd_data_o;
    endtask

    task automatic rd_mask(output logic [8:0] v);
        rd_sel_i = 1'b1; #1; v = rd_data_o;
    endtask

    task automatic pulse(input logic [8:0] p);
        evt_pulse_i = p;
        @(negedge clk_i);
        evt_pulse_i = '0;
    endtask

    task automatic wr(input logic sel, input logic [8:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic t_reset();
        logic [8:0] v;
        rd_evt(v);  chk("R1 event after reset", 16'(v), 16'h000);
        rd_mask(v); chk("R1 mask after reset", 16'(v), 16'h1FF);
        chk("R1 pend after reset", 16'(pend_o), 0);
        chk("R1 irq after reset", 16'(irq_o), 0);
        chk("R1 err after reset", 16'(err_o), 0);
    endtask

    task automatic t_sticky();
        logic [8:0] v;
        pulse(9'h001);
        rd_evt(v); chk("R2 master done set", 16'(v), 16'h001);
        repeat (3) @(negedge clk_i);
        rd_evt(v); chk("R2 flag sticky", 16'(v), 16'h001);
        chk("R6 masked event not pending", 16'(pend_o), 0);
        chk("R8 master done not error", 16'(err_o), 0);
    endtask

    task automatic t_unmask();
        logic [8:0] v;
        wr(1'b1, 9'h1FE);
        rd_mask(v); chk("R5 mask readback", 16'(v), 16'h1FE);
        rd_evt(v);  chk("R9 mask write keeps events", 16'(v), 16'h001);
        chk("R6 pend after unmask", 16'(pend_o), 1);
        chk("R7 irq lags one cycle", 16'(irq_o), 0);
        @(negedge clk_i);
        chk("R7 irq follows pend", 16'(irq_o), 1);
    endtask

    task automatic t_clear();
        logic [8:0] v;
        wr(1'b0, 9'h000);
        rd_evt(v); chk("R3 zero write no effect", 16'(v), 16'h001);
        wr(1'b0, 9'h001);
        rd_evt(v); chk("R3 write one clears", 16'(v), 16'h000);
        chk("R6 pend drops", 16'(pend_o), 0);
        rd_mask(v); chk("R9 event write keeps mask", 16'(v), 16'h1FE);
        @(negedge clk_i);
        chk("R7 irq drops after pend", 16'(irq_o), 0);
    endtask

    task automatic t_collide();
        logic [8:0] v;
        evt_pulse_i = 9'h004;
        wr(1'b0, 9'h004);
        evt_pulse_i = '0;
        rd_evt(v); chk("R4 set wins over clear", 16'(v), 16'h004);
        wr(1'b0, 9'h1FF);
        rd_evt(v); chk("R3 clear all", 16'(v), 16'h000);
    endtask

    task automatic t_accum();
        logic [8:0] v;
        pulse(9'h0A5);
        pulse(9'h100);
        rd_evt(v); chk("R2 pulses accumulate", 16'(v), 16'h1A5);
        wr(1'b0, 9'h0A0);
        rd_evt(v); chk("R3 partial clear", 16'(v), 16'h105);
        wr(1'b0, 9'h1FF);
    endtask

    task automatic t_err();
        logic [8:0] errset;
        errset = 9'h1DA;
        wr(1'b1, 9'h1FF);
        for (int b = 0; b < 9; b++) begin
            pulse(9'(1 << b));
            chk($sformatf("R8 err for bit %0d", b), 16'(err_o), 16'(errset[b]));
            chk($sformatf("R6 fully masked bit %0d", b), 16'(pend_o), 0);
            wr(1'b0, 9'h1FF);
        end
        wr(1'b1, 9'h0FF);
        pulse(9'h100);
        chk("R6 only unmasked bit pends", 16'(pend_o), 1);
        chk("R8 mode mismatch error", 16'(err_o), 1);
        wr(1'b0, 9'h100);
        chk("R8 err clears with event", 16'(err_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_n = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_sticky();
        t_unmask();
        t_clear();
        t_collide();
        t_accum();
        t_err();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule